// File: doc/BRIEF.md
# H-Bridge Protection and Fault Sequencer

This block is the digital control layer of a full H-bridge. Two direction inputs pick, for each half-bridge, whether the high-side or the low-side switch conducts. The block turns those requests into gate commands. It never lets both switches of one leg conduct together, and it puts one idle cycle between them whenever a leg changes side. An enable input and an active-low disable input gate the whole bridge. Either of them, when taken inactive, also clears any latched fault.

Digitized comparator flags come in for current limit, short-circuit overcurrent, overtemperature and supply undervoltage, together with a per-leg "output below ground" flag.

- **Short circuit and overtemperature:** these latch. They command the bridge to high impedance until a clear.
- **Undervoltage:** this forces high impedance only while it lasts, but it leaves a sticky status bit behind.
- **Current limit:** hitting the limit starts a switch-off phase of programmable length. During that phase a leg whose output is below ground may conduct through its low side.
- **Blanking:** overcurrent and current-limit flags are ignored for a programmable number of cycles after any high side turns on.

Active-low status bits are available in parallel for a serial readout path. A mode input can instead route their combination to a single status-flag pin.

Top module: `hbridge_guard`

## Requirements
- R1: With rst_n low at a clock edge, every gate command is off after that edge and all fault latches are clear. With en low, diag_n reads 5'b01111 and all_off is 1.
- R2: Leg i (i = 0 for bit 0, 1 for bit 1) is driven as follows. drv_dir[i]=1 asks for its high side (hs_on[i]) and 0 asks for its low side (ls_on[i]). A change from one side to the other passes through exactly one edge with both gates of that leg off.
- R3: The requested gate is on after the first clock edge at which the bridge is enabled (en=1, dis_n=1, no latched fault, uvolt=0) and the leg was off.
- R4: An overcurrent (ocp) or overtemperature (otemp) flag seen at an edge latches a fault. all_off is 1 right after that edge, and every gate is off one edge later. The latch holds while en and dis_n stay high.
- R5: dis_n low or en low at an edge clears all latched faults and all sticky status bits. all_off stays 1 while either is inactive.
- R6: ocp and ilim are ignored at the BLANK_CYC edges that follow the edge at which any high side turned on.
- R7: An ilim flag seen while a high side is on and blanking is over starts a switch-off phase. It takes all gates off from the next edge for TOFF_CYC edges, after which normal drive resumes. It also clears diag_n[0] until a clear.
- R8: During the switch-off phase, a leg whose below_gnd bit is 1 turns its low side on, at the earliest one edge after its high side went off. Its low side goes off at the first edge after below_gnd drops.
- R9: uvolt=1 forces all_off at once and all gates off at the next edge, only for as long as it is present. It clears diag_n[3], and that bit stays 0 until a clear.
- R10: diag_n is active low: [0] current limit, [1] overtemperature, [2] short circuit, [3] undervoltage, [4] run state (1 only when en=1, dis_n=1 and no short or overtemperature latch). With diag_sel=0, flag_n is the AND of diag_n[3:0]. With diag_sel=1, flag_n is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drv_dir | input | 2 | Per-leg side request, 1 = high side |
| en | input | 1 | Bridge enable, low clears faults |
| dis_n | input | 1 | Active-low disable, low clears faults |
| ilim | input | 1 | Current-limit comparator flag |
| ocp | input | 1 | Short-circuit overcurrent flag |
| otemp | input | 1 | Overtemperature flag |
| uvolt | input | 1 | Supply undervoltage flag |
| below_gnd | input | 2 | Per-leg output below ground |
| diag_sel | input | 1 | 1 = parallel status readout, 0 = status-flag pin |
| hs_on | output | 2 | High-side gate commands |
| ls_on | output | 2 | Low-side gate commands |
| all_off | output | 1 | Tristate command for both legs |
| diag_n | output | 5 | Active-low status bits |
| flag_n | output | 1 | Active-low combined status flag |

## Verification
Two things can meet in the same cycle. One is a direction reversal on a leg. The other is the start of the current-limit phase or a freewheel request on that leg, so the dead-time sequencer and the switch-off timer both act on that leg at once. The bench raises ilim on the edge where blanking has just expired with a high side on. It then asserts below_gnd on that leg and expects one all-off edge before its low side conducts. It also applies ocp inside the blanking window of a freshly turned-on high side and expects the short-circuit bit to stay 1.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
// Shared types for the H-bridge guard: per-leg switch state and the
// bit positions of the active-low status word.
package hbg_pkg;
    localparam int NUM_LEGS = 2;
    localparam int DIAG_W   = 5;
    localparam int D_CLIM   = 0;
    localparam int D_OTEMP  = 1;
    localparam int D_SHORT  = 2;
    localparam int D_UVOLT  = 3;
    localparam int D_RUN    = 4;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_t;
endpackage

// File: rtl/hbg_leg.sv
`timescale 1ns/1ps
// One half-bridge sequencer. Picks the wanted side from the direction
// request, the kill line and the limit phase. Any change from one side
// to the other goes through one all-off cycle.
// Assumes kill and limiting come from the protection unit in this cycle.
module hbg_leg
    import hbg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dir,
    input  logic kill,
    input  logic limiting,
    input  logic below_gnd,
    output logic hs_on,
    output logic ls_on,
    output logic turn_on
);
    leg_t st, tgt, nxt;

    // Wanted side: killed -> off, limit phase -> freewheel only, else by dir.
    always_comb begin
        if (kill)
            tgt = LEG_OFF;
        else if (limiting)
            tgt = below_gnd ? LEG_LO : LEG_OFF;
        else
            tgt = dir ? LEG_HI : LEG_LO;
    end

    // Leaving a conducting side always goes through off first.
    always_comb begin
        if (st != LEG_OFF && tgt != st)
            nxt = LEG_OFF;
        else
            nxt = tgt;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= LEG_OFF;
        else
            st <= nxt;
    end

    assign hs_on   = (st == LEG_HI);
    assign ls_on   = (st == LEG_LO);
    assign turn_on = (nxt == LEG_HI) && (st != LEG_HI);
endmodule

// File: rtl/hbg_protect.sv
`timescale 1ns/1ps
// Protection unit: the blanking timer, the switch-off timer, the fault
// latches and the active-low status word.
// Assumes the comparator flags are already synchronous to clk.
module hbg_protect
    import hbg_pkg::*;
#(
    parameter int BLANK_CYC = 16,
    parameter int TOFF_CYC  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dis_n,
    input  logic              ilim,
    input  logic              ocp,
    input  logic              otemp,
    input  logic              uvolt,
    input  logic              turn_on,
    input  logic              drv_on,
    output logic              kill,
    output logic              limiting,
    output logic [DIAG_W-1:0] diag_n
);
    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam int TW = $clog2(TOFF_CYC + 1);
    localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_CYC);
    localparam logic [TW-1:0] TOFF_LD  = TW'(TOFF_CYC);

    logic [BW-1:0] blank_cnt;
    logic [TW-1:0] toff_cnt;
    logic          cl_l, ot_l, sc_l, uv_l;
    logic          clear, blank_done, lim_evt, sc_evt;

    assign clear      = ~en | ~dis_n;
    assign blank_done = (blank_cnt == '0);
    assign limiting   = (toff_cnt != '0);
    assign kill       = clear | uvolt | ot_l | sc_l;
    assign lim_evt    = ilim & blank_done & ~limiting & ~kill & drv_on;
    assign sc_evt     = ocp & blank_done & ~clear;

    // Blanking timer, reloaded whenever a high side turns on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blank_cnt <= '0;
        else if (turn_on)
            blank_cnt <= BLANK_LD;
        else if (!blank_done)
            blank_cnt <= blank_cnt - 1'b1;
    end

    // Switch-off timer of the current-limit phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            toff_cnt <= '0;
        else if (lim_evt)
            toff_cnt <= TOFF_LD;
        else if (limiting)
            toff_cnt <= toff_cnt - 1'b1;
    end

    // Fault latches and sticky bits, cleared by en or dis_n going inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cl_l <= 1'b0;
            ot_l <= 1'b0;
            sc_l <= 1'b0;
            uv_l <= 1'b0;
        end else begin
            cl_l <= cl_l | lim_evt;
            ot_l <= ot_l | otemp;
            sc_l <= sc_l | sc_evt;
            uv_l <= uv_l | uvolt;
        end
    end

    // Active-low status word.
    always_comb begin
        diag_n          = '1;
        diag_n[D_CLIM]  = ~cl_l;
        diag_n[D_OTEMP] = ~ot_l;
        diag_n[D_SHORT] = ~sc_l;
        diag_n[D_UVOLT] = ~uv_l;
        diag_n[D_RUN]   = ~clear & ~ot_l & ~sc_l;
    end
endmodule

// File: rtl/hbridge_guard.sv
`timescale 1ns/1ps
// Top of the H-bridge guard: two leg sequencers under one protection
// unit, plus the selection of the status-flag pin.
// Assumes all inputs are synchronous to clk.
module hbridge_guard
    import hbg_pkg::*;
#(
    parameter int BLANK_CYC = 16,
    parameter int TOFF_CYC  = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_LEGS-1:0] drv_dir,
    input  logic                en,
    input  logic                dis_n,
    input  logic                ilim,
    input  logic                ocp,
    input  logic                otemp,
    input  logic                uvolt,
    input  logic [NUM_LEGS-1:0] below_gnd,
    input  logic                diag_sel,
    output logic [NUM_LEGS-1:0] hs_on,
    output logic [NUM_LEGS-1:0] ls_on,
    output logic                all_off,
    output logic [DIAG_W-1:0]   diag_n,
    output logic                flag_n
);
    logic [NUM_LEGS-1:0] turn_vec;
    logic                kill, limiting;

    hbg_protect #(.BLANK_CYC(BLANK_CYC), .TOFF_CYC(TOFF_CYC)) u_prot (
        .clk(clk), .rst_n(rst_n), .en(en), .dis_n(dis_n),
        .ilim(ilim), .ocp(ocp), .otemp(otemp), .uvolt(uvolt),
        .turn_on(|turn_vec), .drv_on(|hs_on),
        .kill(kill), .limiting(limiting), .diag_n(diag_n)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbg_leg u_leg (
            .clk(clk), .rst_n(rst_n), .dir(drv_dir[g]),
            .kill(kill), .limiting(limiting), .below_gnd(below_gnd[g]),
            .hs_on(hs_on[g]), .ls_on(ls_on[g]), .turn_on(turn_vec[g])
        );
    end

    assign all_off = kill;
    // The flag pin carries the fault bits only in flag mode.
    assign flag_n  = diag_sel | (&diag_n[D_UVOLT:D_CLIM]);
endmodule

// File: rtl/hbridge_guard_chk.sv
`timescale 1ns/1ps
// Property checker for hbridge_guard, attached through bind.
module hbridge_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       dis_n,
    input logic       ocp,
    input logic       uvolt,
    input logic       diag_sel,
    input logic [1:0] hs_on,
    input logic [1:0] ls_on,
    input logic       all_off,
    input logic [4:0] diag_n,
    input logic       flag_n
);
    // R2: a conducting high side is never followed directly by its low side.
    a_r2_dead_leg0: assert property (@(posedge clk) disable iff (!rst_n)
        hs_on[0] |=> !ls_on[0]);
    a_r2_dead_leg1: assert property (@(posedge clk) disable iff (!rst_n)
        hs_on[1] |=> !ls_on[1]);
    // R4: the tristate command empties every gate one edge later.
    a_r4_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |=> (hs_on == 2'b00 && ls_on == 2'b00));
    // R4: a latched short holds while not cleared.
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!diag_n[2] && en && dis_n) |=> !diag_n[2]);
    // R6: overcurrent right after a high side turns on is blanked.
    a_r6_blank: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_on[1]) && ocp && diag_n[2]) |=> diag_n[2]);
    // R9: undervoltage removes all gates and is recorded.
    a_r9_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
        uvolt |=> (hs_on == 2'b00 && ls_on == 2'b00));
    a_r9_uv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (uvolt && en && dis_n) |=> !diag_n[3]);
    // R10: in flag mode any fault bit pulls the flag low.
    a_r10_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!diag_sel && diag_n[3:0] != 4'hF) |-> !flag_n);
endmodule

bind hbridge_guard hbridge_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .dis_n(dis_n), .ocp(ocp),
    .uvolt(uvolt), .diag_sel(diag_sel), .hs_on(hs_on), .ls_on(ls_on),
    .all_off(all_off), .diag_n(diag_n), .flag_n(flag_n)
);

// File: tb/hbridge_guard_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected outputs after each
// checked edge, the monitor compares them at the following falling edge.
module hbridge_guard_test;
    typedef struct packed {
        logic [1:0] hs;
        logic [1:0] ls;
        logic       off;
        logic [4:0] diag;
        logic       flag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] drv_dir = 2'b00;
    logic       en = 1'b0, dis_n = 1'b1, ilim = 1'b0, ocp = 1'b0;
    logic       otemp = 1'b0, uvolt = 1'b0, diag_sel = 1'b1;
    logic [1:0] below_gnd = 2'b00;
    logic [1:0] hs_on, ls_on;
    logic       all_off, flag_n;
    logic [4:0] diag_n;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    exp_t  q_exp[$];
    string q_req[$];

    always #4 clk = ~clk;

    hbridge_guard #(.BLANK_CYC(4), .TOFF_CYC(6)) uut (
        .clk(clk), .rst_n(rst_n), .drv_dir(drv_dir), .en(en), .dis_n(dis_n),
        .ilim(ilim), .ocp(ocp), .otemp(otemp), .uvolt(uvolt),
        .below_gnd(below_gnd), .diag_sel(diag_sel), .hs_on(hs_on),
        .ls_on(ls_on), .all_off(all_off), .diag_n(diag_n), .flag_n(flag_n)
    );

    // Advance one edge and queue the outputs expected after it.
    task automatic chk(input string req, input logic [1:0] hs, input logic [1:0] ls,
                       input logic off, input logic [4:0] dg, input logic fl);
        exp_t e;
        e = '{hs: hs, ls: ls, off: off, diag: dg, flag: fl};
        @(posedge clk);
        q_exp.push_back(e);
        q_req.push_back(req);
        @(negedge clk);
        #1;
    endtask

    // Advance edges without checks.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    // Monitor: compare the design's outputs against the queued item.
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            exp_t  e;
            exp_t  a;
            string r;
            e = q_exp.pop_front();
            r = q_req.pop_front();
            a = '{hs: hs_on, ls: ls_on, off: all_off, diag: diag_n, flag: flag_n};
            n_chk++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: hs=%b ls=%b off=%b diag=%b flag=%b expected hs=%b ls=%b off=%b diag=%b flag=%b",
                         r, a.hs, a.ls, a.off, a.diag, a.flag, e.hs, e.ls, e.off, e.diag, e.flag);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk("R1 reset", 2'b00, 2'b00, 1, 5'b01111, 1);
        rst_n = 1; en = 1; drv_dir = 2'b01;
        chk("R3 enable drive", 2'b01, 2'b10, 0, 5'b11111, 1);
        drv_dir = 2'b10;
        chk("R2 dead cycle", 2'b00, 2'b00, 0, 5'b11111, 1);
        chk("R2 reversed", 2'b10, 2'b01, 0, 5'b11111, 1);
        ocp = 1;
        chk("R6 blank edge1", 2'b10, 2'b01, 0, 5'b11111, 1);
        chk("R6 blank edge2", 2'b10, 2'b01, 0, 5'b11111, 1);
        ocp = 0;
        tick(3);
        ilim = 1;
        chk("R7 limit start", 2'b10, 2'b01, 0, 5'b11110, 1);
        ilim = 0; below_gnd = 2'b10;
        chk("R7 off phase", 2'b00, 2'b00, 0, 5'b11110, 1);
        chk("R8 freewheel on", 2'b00, 2'b10, 0, 5'b11110, 1);
        below_gnd = 2'b00;
        chk("R8 freewheel end", 2'b00, 2'b00, 0, 5'b11110, 1);
        tick(2);
        chk("R7 last off edge", 2'b00, 2'b00, 0, 5'b11110, 1);
        chk("R7 resume", 2'b10, 2'b01, 0, 5'b11110, 1);
        tick(4);
        ocp = 1;
        chk("R4 short latch", 2'b10, 2'b01, 1, 5'b01010, 1);
        ocp = 0;
        chk("R4 gates off", 2'b00, 2'b00, 1, 5'b01010, 1);
        diag_sel = 0;
        chk("R10 flag mode", 2'b00, 2'b00, 1, 5'b01010, 0);
        dis_n = 0;
        chk("R5 clear by dis_n", 2'b00, 2'b00, 1, 5'b01111, 1);
        dis_n = 1;
        chk("R5 restart", 2'b10, 2'b01, 0, 5'b11111, 1);
        otemp = 1;
        chk("R4 otemp latch", 2'b10, 2'b01, 1, 5'b01101, 0);
        otemp = 0;
        chk("R4 otemp off", 2'b00, 2'b00, 1, 5'b01101, 0);
        en = 0;
        chk("R5 clear by en", 2'b00, 2'b00, 1, 5'b01111, 1);
        en = 1;
        chk("R3 drive again", 2'b10, 2'b01, 0, 5'b11111, 1);
        uvolt = 1;
        chk("R9 uv tristate", 2'b00, 2'b00, 1, 5'b10111, 0);
        uvolt = 0;
        chk("R9 uv gone sticky", 2'b10, 2'b01, 0, 5'b10111, 0);
        dis_n = 0;
        chk("R9 sticky cleared", 2'b00, 2'b00, 1, 5'b01111, 1);
        dis_n = 1; diag_sel = 1;
        chk("R10 serial mode", 2'b10, 2'b01, 0, 5'b11111, 1);
        tick(1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule